// File: doc/BRIEF.md
# Dual Gated Timer/Counter with Overflow Flags

This block provides two 16-bit timer/counter channels for a small processor subsystem. Each channel advances either on an internal machine-cycle tick or on falling edges seen on its own external count pin. Its run condition is the software run bit, optionally qualified by the level of an external gate pin. A processor configures the channels through an 8-bit register port: a control byte with run bits and overflow flags, a mode byte with per-channel gate, source and mode fields, and four count bytes.

When a channel wraps past its top count, it raises its overflow flag. An interrupt controller outside the block sees the flag and later returns an acknowledge pulse for that channel, which clears the flag. Software may also write the flags directly through the control byte. Four counting modes are supported: a 13-bit counter with a 5-bit prescaler, a 16-bit counter, an 8-bit counter with automatic reload, and a split mode that turns channel 0 into two independent 8-bit counters.

All inputs are assumed to be synchronous to `clk`. The tick input is a one-cycle enable that marks each machine cycle.

Top module: `tmr_pair`

## Requirements
- R1: After synchronous reset, both flags, both run bits, the mode byte and all count bytes are 0, and `reg_rdata` is 0.
- R2: Register addresses: 0 control, 1 mode, 2/3 channel 0 low/high byte, 4/5 channel 1 low/high byte. Other addresses read 0. Control byte: bit 7 flag 1, bit 6 run 1, bit 5 flag 0, bit 4 run 0; bits 3..0 read 0. Mode byte: bits 7..4 belong to channel 1 and bits 3..0 to channel 0, each as {gate, external source, mode[1:0]}. Read data is registered and appears one cycle after the address.
- R3: With the internal source selected, a running channel advances by one on each cycle that `tick` is high. With its run bit at 0, a channel holds its count.
- R4: With the gate bit at 1, a channel advances only while its `gate_pin` is high, in addition to its run bit.
- R5: With the external source selected, the count pin is sampled on every tick. The channel advances once for each 1-to-0 change between two consecutive samples. Steady levels and rising changes do not advance it.
- R6: Mode 01 is a 16-bit counter. It wraps from FFFF to 0000 and sets the channel flag.
- R7: Mode 00 is a 13-bit counter. Low-byte bits 4..0 act as a prescaler, and the high byte advances when they wrap. Low-byte bits 7..5 are left untouched. The flag is set when the high byte is FF and the prescaler is 1F at a count.
- R8: Mode 10 counts the low byte. When the low byte wraps from FF, it is loaded with the high byte and the flag is set.
- R9: When channel 0 is in mode 11, its low byte counts under channel 0 controls and sets flag 0, and its high byte counts ticks under run bit 1 and sets flag 1. In this state channel 1 still counts but cannot set flag 1. When channel 1 itself is in mode 11, it holds its count.
- R10: An acknowledge pulse clears the matching flag in the next cycle. An overflow in the same cycle wins, and the flag stays set.
- R11: A control-byte write loads both flags from the written data, and it wins over a hardware overflow in the same cycle.
- R12: A write to a count byte wins over an increment in the same cycle, and that increment raises no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Internal machine-cycle count enable |
| cnt_pin | input | 2 | External count inputs, one per channel |
| gate_pin | input | 2 | External gate levels, one per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq_ack | input | 2 | Per-channel acknowledge pulses that clear the flags |
| ovf_flag | output | 2 | Per-channel overflow flags |

## Verification
The bench targets the same-cycle collisions:
- A flag write during an overflow. A design that lets hardware win would leave the flag set.
- An acknowledge during an overflow. A design that lets the acknowledge win would lose the interrupt.
- A count write during an increment. A design that lets the increment win would skip the loaded value or raise a flag.

The bench also checks mode-specific wrap points:
- The 13-bit prescaler must keep low-byte bits 7..5. A plain 16-bit add would carry into them.
- The reload mode must resume counting from the high byte.
- In split mode, the carry must be routed to flag 1. A wrong routing would let channel 1 raise the flag, or would fail to stop channel 1.

For the external source, a pattern of repeated and rising levels tells true edge counting apart from level counting.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int NCH    = 2;

  localparam int A_CTRL = 0;
  localparam int A_MODE = 1;
  localparam int A_C0L  = 2;

  typedef enum logic [1:0] {
    MD_13B   = 2'b00,
    MD_16B   = 2'b01,
    MD_8RL   = 2'b10,
    MD_SPLIT = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } chan_cfg_t;
endpackage

// File: rtl/tmr_evt.sv
module tmr_evt
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      cnt_pin,
  input  logic      gate_pin,
  input  logic      run,
  input  chan_cfg_t cfg,
  output logic      inc
);
  logic smp_q;
  logic fall;
  logic allow;

  // pin sampled once per machine tick; edge is judged between samples
  always_ff @(posedge clk) begin
    if (rst)       smp_q <= 1'b0;
    else if (tick) smp_q <= cnt_pin;
  end

  assign fall  = smp_q & ~cnt_pin;
  assign allow = run & (~cfg.gate | gate_pin);
  assign inc   = tick & allow & (cfg.ext ? fall : 1'b1);
endmodule

// File: rtl/tmr_chan_core.sv
module tmr_chan_core
  import tmr_pkg::*;
#(
  parameter int W     = 8,
  parameter int PRE_W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  tmr_mode_e    mode,
  input  logic         inc_lo,
  input  logic         inc_hi,
  input  logic         we_lo,
  input  logic         we_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic         wrap_lo,
  output logic         wrap_hi
);
  localparam logic [W-1:0]     ONE_B = 1;
  localparam logic [PRE_W-1:0] ONE_P = 1;
  localparam logic [2*W-1:0]   ONE_D = 1;

  logic [W-1:0] lo_n, hi_n;
  logic         busy, lo_ones, hi_ones, pre_ones;

  assign busy     = we_lo | we_hi;
  assign lo_ones  = &cnt_lo;
  assign hi_ones  = &cnt_hi;
  assign pre_ones = &cnt_lo[PRE_W-1:0];

  always_comb begin
    lo_n    = cnt_lo;
    hi_n    = cnt_hi;
    wrap_lo = 1'b0;
    wrap_hi = 1'b0;
    if (!busy) begin
      unique case (mode)
        MD_13B: if (inc_lo) begin
          lo_n[PRE_W-1:0] = cnt_lo[PRE_W-1:0] + ONE_P;
          if (pre_ones) begin
            hi_n    = cnt_hi + ONE_B;
            wrap_lo = hi_ones;
          end
        end
        MD_16B: if (inc_lo) begin
          {hi_n, lo_n} = {cnt_hi, cnt_lo} + ONE_D;
          wrap_lo      = lo_ones & hi_ones;
        end
        MD_8RL: if (inc_lo) begin
          if (lo_ones) begin
            lo_n    = cnt_hi;
            wrap_lo = 1'b1;
          end else begin
            lo_n = cnt_lo + ONE_B;
          end
        end
        MD_SPLIT: begin
          if (inc_lo) begin
            lo_n    = cnt_lo + ONE_B;
            wrap_lo = lo_ones;
          end
          if (inc_hi) begin
            hi_n    = cnt_hi + ONE_B;
            wrap_hi = hi_ones;
          end
        end
        default: ;
      endcase
    end
    if (we_lo) lo_n = wdata;
    if (we_hi) hi_n = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      cnt_lo <= lo_n;
      cnt_hi <= hi_n;
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int PRE_W = 5,
  parameter int AW    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [NCH-1:0]    cnt_pin,
  input  logic [NCH-1:0]    gate_pin,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [NCH-1:0]    irq_ack,
  output logic [NCH-1:0]    ovf_flag
);
  localparam int CFG_W = $bits(chan_cfg_t);

  logic [NCH-1:0]              run_q, ovf_q, set_ovf;
  logic [NCH*CFG_W-1:0]        mode_q;
  chan_cfg_t [NCH-1:0]         cfg;
  logic [NCH-1:0]              inc, inc_lo, inc_hi, we_lo, we_hi;
  logic [NCH-1:0]              wrap_lo, wrap_hi;
  logic [NCH-1:0][BYTE_W-1:0]  cnt_lo, cnt_hi;
  logic                        ctrl_we, mode_we, split0;
  logic [BYTE_W-1:0]           rd_mux;

  assign cfg     = mode_q;
  assign ctrl_we = reg_we && (reg_addr == AW'(A_CTRL));
  assign mode_we = reg_we && (reg_addr == AW'(A_MODE));
  assign split0  = (cfg[0].mode == MD_SPLIT);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign we_lo[i] = reg_we && (reg_addr == AW'(A_C0L + 2 * i));
    assign we_hi[i] = reg_we && (reg_addr == AW'(A_C0L + 2 * i + 1));

    tmr_evt u_evt (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .cnt_pin  (cnt_pin[i]),
      .gate_pin (gate_pin[i]),
      .run      (run_q[i]),
      .cfg      (cfg[i]),
      .inc      (inc[i])
    );

    if (i == 0) begin : g_lead
      // split mode: upper half becomes a plain tick counter owned by run bit 1
      assign inc_lo[i] = inc[i];
      assign inc_hi[i] = tick & run_q[1] & split0;
    end else begin : g_follow
      // a non-leading channel in split mode stops
      assign inc_lo[i] = inc[i] & (cfg[i].mode != MD_SPLIT);
      assign inc_hi[i] = 1'b0;
    end

    tmr_chan_core #(.W(BYTE_W), .PRE_W(PRE_W)) u_core (
      .clk     (clk),
      .rst     (rst),
      .mode    (cfg[i].mode),
      .inc_lo  (inc_lo[i]),
      .inc_hi  (inc_hi[i]),
      .we_lo   (we_lo[i]),
      .we_hi   (we_hi[i]),
      .wdata   (reg_wdata),
      .cnt_lo  (cnt_lo[i]),
      .cnt_hi  (cnt_hi[i]),
      .wrap_lo (wrap_lo[i]),
      .wrap_hi (wrap_hi[i])
    );
  end

  // flag 1 is borrowed by channel 0's upper half while it is split
  assign set_ovf[0] = wrap_lo[0];
  assign set_ovf[1] = split0 ? wrap_hi[0] : (wrap_lo[1] | wrap_hi[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      ovf_q  <= '0;
      mode_q <= '0;
    end else begin
      if (ctrl_we) begin
        run_q <= {reg_wdata[6], reg_wdata[4]};
        ovf_q <= {reg_wdata[7], reg_wdata[5]};
      end else begin
        ovf_q <= (ovf_q & ~irq_ack) | set_ovf;
      end
      if (mode_we) mode_q <= reg_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      AW'(A_CTRL):    rd_mux = {ovf_q[1], run_q[1], ovf_q[0], run_q[0], 4'b0000};
      AW'(A_MODE):    rd_mux = mode_q;
      AW'(A_C0L):     rd_mux = cnt_lo[0];
      AW'(A_C0L + 1): rd_mux = cnt_hi[0];
      AW'(A_C0L + 2): rd_mux = cnt_lo[1];
      AW'(A_C0L + 3): rd_mux = cnt_hi[1];
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign ovf_flag = ovf_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
(
  input logic                       clk,
  input logic                       rst,
  input logic                       ctrl_we,
  input logic [BYTE_W-1:0]          reg_wdata,
  input logic [BYTE_W-1:0]          reg_rdata,
  input logic [NCH-1:0]             irq_ack,
  input logic [NCH-1:0]             set_ovf,
  input logic [NCH-1:0]             ovf_flag,
  input logic [NCH-1:0]             run_q,
  input logic [NCH*4-1:0]           mode_q,
  input logic [NCH-1:0]             gate_pin,
  input logic [NCH-1:0][BYTE_W-1:0] cnt_lo,
  input logic [NCH-1:0]             we_lo,
  input logic [NCH-1:0]             we_hi
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ovf_flag == '0 && run_q == '0 && reg_rdata == '0));

  assert_halt_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (!run_q[0] && !we_lo[0] && !we_hi[0]) |=> $stable(cnt_lo[0]));

  assert_gate_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q[3] && !gate_pin[0] && !we_lo[0] && !we_hi[0]) |=> $stable(cnt_lo[0]));

  assert_flag_source_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag[0]) |-> $past(set_ovf[0] || ctrl_we));

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_ack[0] && !ctrl_we && !set_ovf[0]) |=> !ovf_flag[0]);

  assert_sw_wins_R11: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> (ovf_flag == {$past(reg_wdata[7]), $past(reg_wdata[5])}));
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctrl_we   (ctrl_we),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_ack   (irq_ack),
  .set_ovf   (set_ovf),
  .ovf_flag  (ovf_flag),
  .run_q     (run_q),
  .mode_q    (mode_q),
  .gate_pin  (gate_pin),
  .cnt_lo    (cnt_lo),
  .we_lo     (we_lo),
  .we_hi     (we_hi)
);

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] cnt_pin = '0;
  logic [1:0] gate_pin = '0;
  logic [1:0] irq_ack = '0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] ovf_flag;

  always #2 clk = ~clk;

  tmr_pair u0 (
    .clk(clk), .rst(rst), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ack(irq_ack), .ovf_flag(ovf_flag)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
    int         due;
  } item_t;
  item_t sbq[$];
  item_t cur;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare registered read data in the cycle each item falls due
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      cur = sbq.pop_front();
      n_chk++;
      if (reg_rdata !== cur.exp) begin
        n_fail++;
        $display("FAIL %s: read %h expected %h", cur.tag, reg_rdata, cur.exp);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    sbq.push_back('{e, t, cyc + 1});
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pin_tick(input logic v);
    @(negedge clk); cnt_pin[0] = v; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic chk_flag(input logic [1:0] e, input string t);
    n_chk++;
    if (ovf_flag !== e) begin
      n_fail++;
      $display("FAIL %s: flags %b expected %b", t, ovf_flag, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_flag(2'b00, "R1 flags");
    rd(3'd0, 8'h00, "R1 ctrl");
    rd(3'd1, 8'h00, "R1 mode");
    rd(3'd2, 8'h00, "R1 cnt0 lo");
    rd(3'd5, 8'h00, "R1 cnt1 hi");
    step(2);
    rd(3'd2, 8'h00, "R3 idle after reset");
    // R2 map
    wr(3'd1, 8'h11);
    rd(3'd1, 8'h11, "R2 mode");
    rd(3'd7, 8'h00, "R2 unmapped");
    wr(3'd2, 8'h10); wr(3'd3, 8'h00);
    wr(3'd0, 8'h1F);
    rd(3'd0, 8'h10, "R2 ctrl low nibble");
    // R3 run and halt
    step(5);
    rd(3'd2, 8'h15, "R3 counting");
    wr(3'd0, 8'h00);
    step(3);
    rd(3'd2, 8'h15, "R3 halted");
    // R6 16-bit wrap
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd0, 8'h10);
    step(1);
    chk_flag(2'b00, "R6 before wrap");
    step(1);
    chk_flag(2'b01, "R6 wrap sets flag");
    rd(3'd2, 8'h00, "R6 lo");
    rd(3'd3, 8'h00, "R6 hi");
    rd(3'd0, 8'h30, "R2 ctrl shows flag");
    // R10 acknowledge
    @(negedge clk); irq_ack = 2'b01;
    @(negedge clk); irq_ack = 2'b00;
    chk_flag(2'b00, "R10 ack clears");
    // R11 software flag writes
    wr(3'd0, 8'h20);
    chk_flag(2'b01, "R11 write sets");
    wr(3'd0, 8'h00);
    chk_flag(2'b00, "R11 write clears");
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd0, 8'h10);
    @(negedge clk); tick = 1'b1; reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h10;
    @(negedge clk); tick = 1'b0; reg_we = 1'b0;
    chk_flag(2'b00, "R11 write beats overflow");
    rd(3'd2, 8'h00, "R11 count still wrapped");
    // R10 overflow beats acknowledge
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    @(negedge clk); tick = 1'b1; irq_ack = 2'b01;
    @(negedge clk); tick = 1'b0; irq_ack = 2'b00;
    chk_flag(2'b01, "R10 overflow beats ack");
    wr(3'd0, 8'h10);
    // R12 count write beats increment
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    @(negedge clk); tick = 1'b1; reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h40;
    @(negedge clk); tick = 1'b0; reg_we = 1'b0;
    chk_flag(2'b00, "R12 no flag");
    rd(3'd2, 8'h40, "R12 lo loaded");
    rd(3'd3, 8'hFF, "R12 hi untouched");
    // R4 gate
    wr(3'd0, 8'h00); wr(3'd1, 8'h19); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h10);
    gate_pin[0] = 1'b0;
    step(3);
    rd(3'd2, 8'h00, "R4 gate low holds");
    gate_pin[0] = 1'b1;
    step(3);
    rd(3'd2, 8'h03, "R4 gate high counts");
    // R5 external edges
    wr(3'd1, 8'h15); wr(3'd2, 8'h00);
    pin_tick(1'b1); pin_tick(1'b1);
    rd(3'd2, 8'h00, "R5 rising and steady ignored");
    pin_tick(1'b0); pin_tick(1'b0); pin_tick(1'b1); pin_tick(1'b0); pin_tick(1'b1);
    rd(3'd2, 8'h02, "R5 two falling edges");
    cnt_pin[0] = 1'b0;
    // R7 13-bit mode
    wr(3'd1, 8'h10); wr(3'd2, 8'hFE); wr(3'd3, 8'h05);
    step(1);
    rd(3'd2, 8'hFF, "R7 prescale");
    step(1);
    rd(3'd2, 8'hE0, "R7 upper low bits kept");
    rd(3'd3, 8'h06, "R7 high carry");
    wr(3'd2, 8'h1F); wr(3'd3, 8'hFF);
    step(1);
    chk_flag(2'b01, "R7 13-bit wrap flag");
    rd(3'd3, 8'h00, "R7 hi wrapped");
    rd(3'd2, 8'h00, "R7 lo wrapped");
    // R8 auto-reload
    wr(3'd0, 8'h10); wr(3'd1, 8'h12); wr(3'd3, 8'hF0); wr(3'd2, 8'hFE);
    step(1);
    chk_flag(2'b00, "R8 before wrap");
    step(1);
    chk_flag(2'b01, "R8 wrap flag");
    rd(3'd2, 8'hF0, "R8 reloaded");
    step(1);
    rd(3'd2, 8'hF1, "R8 counts from reload");
    // R9 split mode
    wr(3'd0, 8'h00); wr(3'd1, 8'h13);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFE); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    wr(3'd0, 8'h50);
    step(1);
    chk_flag(2'b01, "R9 low half flag, ch1 wrap silent");
    rd(3'd4, 8'h00, "R9 ch1 lo counts");
    rd(3'd5, 8'h00, "R9 ch1 hi counts");
    step(1);
    chk_flag(2'b11, "R9 high half sets flag 1");
    rd(3'd3, 8'h00, "R9 ch0 hi wrapped");
    rd(3'd4, 8'h01, "R9 ch1 lo");
    rd(3'd2, 8'h01, "R9 ch0 lo");
    wr(3'd0, 8'h10);
    step(1);
    rd(3'd3, 8'h00, "R9 high half needs run 1");
    rd(3'd2, 8'h02, "R9 low half runs");
    wr(3'd1, 8'h33); wr(3'd0, 8'h50);
    step(2);
    rd(3'd4, 8'h01, "R9 ch1 holds in split");
    rd(3'd3, 8'h02, "R9 high half counts");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule